// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the microprogram counter of a microcoded control unit and works out, once per clock, the address of the next microinstruction. The current microinstruction supplies a 9-bit successor address. It also supplies two condition-select bits and a dispatch bit. The sequencer combines these with the ALU sign and zero results of the same cycle and with an 8-bit instruction byte register that it keeps itself.

The successor address is built by OR-ing, not by adding. Bit 8 is the successor's bit 8, forced high when a selected condition holds. A two-way branch therefore lands either on the successor label or on the label 0x100 above it. Bits 7..0 are the successor's low bits, OR-ed with the byte register when dispatch is requested. A successor of 0x000 gives a plain opcode dispatch, and a successor of 0x100 gives a dispatch into the upper page. The byte register can be loaded in the same cycle as the dispatch, and the dispatch then uses the newly loaded byte.

The control store and the datapath sit outside this block. The control store reads `upc` as its address.

Top module: `useq_seq`

## Requirements
- R1: While `rst_n` is low, `upc` is 0x000 and `op_byte` is 0x00. Reset is asynchronous.
- R2: With `sel_neg`, `sel_zero` and `dispatch` all low, `upc` takes `succ_addr` at the next rising edge, whatever the values of `alu_neg` and `alu_zero`.
- R3: With `sel_zero` high, bit 8 of the next `upc` is `succ_addr[8]` OR `alu_zero`. The value used is the `alu_zero` present in that same cycle, not an earlier one.
- R4: With `sel_neg` high, bit 8 of the next `upc` is `succ_addr[8]` OR `alu_neg`, again using the same-cycle value.
- R5: With both select bits high, bit 8 of the next `upc` is set when either flag is set, or when `succ_addr[8]` is set.
- R6: With `dispatch` high, bits 7..0 of the next `upc` are `succ_addr[7:0]` OR the byte register. The byte bits are OR-ed, not added.
- R7: A dispatch with `succ_addr` = 0x100 yields 0x100 OR the byte register.
- R8: With `byte_load` high, `op_byte` takes `byte_in` at the next edge. A dispatch in that same cycle uses `byte_in` rather than the old register value.
- R9: A dispatch combined with a condition select produces both effects at once: the byte is OR-ed into bits 7..0, and the selected flag sets bit 8.
- R10: With `dispatch` low, the byte register and `byte_in` have no effect on `upc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| succ_addr | input | 9 | Successor address field of the current microinstruction |
| sel_neg | input | 1 | Branch on the ALU sign result |
| sel_zero | input | 1 | Branch on the ALU zero result |
| dispatch | input | 1 | OR the instruction byte into bits 7..0 |
| alu_neg | input | 1 | ALU sign result of this cycle |
| alu_zero | input | 1 | ALU zero result of this cycle |
| byte_load | input | 1 | Load the instruction byte register |
| byte_in | input | 8 | New instruction byte |
| upc | output | 9 | Microprogram counter |
| op_byte | output | 8 | Instruction byte register |

## Verification
The bench goes after the same-cycle cases. A dispatch issued while the byte register is being loaded must produce the new byte. A design without the bypass would jump to the previous opcode's routine. A branch that follows a cycle with a different flag value must use the current flag. A one-cycle flag delay would take the wrong arm. The bench also checks that dispatch OR-s rather than adds: successor 0x00F with byte 0x81 must give 0x08F, while an adder would give 0x090. Further checks cover the mix of dispatch and condition, and the rule that a flag is ignored when no select bit is set.

// File: rtl/useq_seq.sv
module useq_seq #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BYTE_W:0]     succ_addr,
  input  logic                sel_neg,
  input  logic                sel_zero,
  input  logic                dispatch,
  input  logic                alu_neg,
  input  logic                alu_zero,
  input  logic                byte_load,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic [BYTE_W:0]     upc,
  output logic [BYTE_W-1:0]   op_byte
);
  localparam int ADDR_W = BYTE_W + 1;

  logic [BYTE_W-1:0] byte_eff;
  logic [BYTE_W-1:0] low_or;
  logic              page_bit;
  logic [ADDR_W-1:0] upc_d;

  // Same-cycle load is bypassed so a dispatch sees the new byte.
  assign byte_eff = byte_load ? byte_in : op_byte;
  assign low_or   = dispatch ? byte_eff : '0;
  assign page_bit = succ_addr[BYTE_W] | (sel_neg & alu_neg) | (sel_zero & alu_zero);
  assign upc_d    = {page_bit, succ_addr[BYTE_W-1:0] | low_or};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc     <= '0;
      op_byte <= '0;
    end else begin
      upc <= upc_d;
      if (byte_load) op_byte <= byte_in;
    end
  end

  assert_plain_jump_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_neg && !sel_zero && !dispatch) |=> upc == $past(succ_addr));

  assert_zero_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_zero && !sel_neg) |=> upc[BYTE_W] == ($past(succ_addr[BYTE_W]) | $past(alu_zero)));

  assert_neg_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_neg && !sel_zero) |=> upc[BYTE_W] == ($past(succ_addr[BYTE_W]) | $past(alu_neg)));

  assert_dispatch_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> upc[BYTE_W-1:0] == ($past(succ_addr[BYTE_W-1:0]) | op_byte));

  assert_byte_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load |=> op_byte == $past(byte_in));

  assert_no_dispatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |=> upc[BYTE_W-1:0] == $past(succ_addr[BYTE_W-1:0]));
endmodule

// File: tb/useq_seq_tb.sv
module useq_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] succ_addr = '0;
  logic       sel_neg = 1'b0, sel_zero = 1'b0, dispatch = 1'b0;
  logic       alu_neg = 1'b0, alu_zero = 1'b0, byte_load = 1'b0;
  logic [7:0] byte_in = '0;
  logic [8:0] upc;
  logic [7:0] op_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  useq_seq u_dut (
    .clk(clk), .rst_n(rst_n), .succ_addr(succ_addr), .sel_neg(sel_neg),
    .sel_zero(sel_zero), .dispatch(dispatch), .alu_neg(alu_neg),
    .alu_zero(alu_zero), .byte_load(byte_load), .byte_in(byte_in),
    .upc(upc), .op_byte(op_byte)
  );

  // {succ 9, sel_neg sel_zero dispatch alu_neg alu_zero byte_load, byte_in 8, exp upc 9, exp byte 8}
  localparam logic [39:0] VEC [16] = '{
    {9'h005, 6'b000110, 8'h00, 9'h005, 8'h00},  // R2 flags ignored
    {9'h010, 6'b010010, 8'h00, 9'h110, 8'h00},  // R3 zero taken
    {9'h010, 6'b010100, 8'h00, 9'h010, 8'h00},  // R3 same-cycle zero clear
    {9'h020, 6'b100100, 8'h00, 9'h120, 8'h00},  // R4 neg taken
    {9'h021, 6'b100010, 8'h00, 9'h021, 8'h00},  // R4 neg clear
    {9'h030, 6'b110010, 8'h00, 9'h130, 8'h00},  // R5 either flag
    {9'h030, 6'b110000, 8'h00, 9'h030, 8'h00},  // R5 neither flag
    {9'h040, 6'b000001, 8'h5A, 9'h040, 8'h5A},  // R10 load without dispatch
    {9'h000, 6'b001000, 8'h00, 9'h05A, 8'h5A},  // R6 plain dispatch
    {9'h100, 6'b001000, 8'h00, 9'h15A, 8'h5A},  // R7 upper-page dispatch
    {9'h000, 6'b001001, 8'hC3, 9'h0C3, 8'hC3},  // R8 load and dispatch
    {9'h100, 6'b001001, 8'h3C, 9'h13C, 8'h3C},  // R8 load and upper dispatch
    {9'h0FF, 6'b000001, 8'h81, 9'h0FF, 8'h81},  // R10 byte ignored
    {9'h00F, 6'b001000, 8'h00, 9'h08F, 8'h81},  // R6 OR, not add
    {9'h000, 6'b011010, 8'h00, 9'h181, 8'h81},  // R9 dispatch plus zero branch
    {9'h1FF, 6'b000000, 8'h00, 9'h1FF, 8'h81}   // R2 full address
  };
  localparam int REQ [16] = '{2, 3, 3, 4, 4, 5, 5, 10, 6, 7, 8, 8, 10, 6, 9, 2};

  task automatic check(input string req, input logic [8:0] got_pc, input logic [8:0] exp_pc,
                       input logic [7:0] got_b, input logic [7:0] exp_b);
    checks++;
    if (got_pc !== exp_pc || got_b !== exp_b) begin
      errors++;
      $display("FAIL %s: upc=%h op_byte=%h expected upc=%h op_byte=%h",
               req, got_pc, got_b, exp_pc, exp_b);
    end
  endtask

  initial begin
    #2;
    check("R1", upc, 9'h000, op_byte, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      succ_addr = VEC[i][39:31];
      {sel_neg, sel_zero, dispatch, alu_neg, alu_zero, byte_load} = VEC[i][30:25];
      byte_in = VEC[i][24:17];
      @(negedge clk);
      check($sformatf("R%0d row %0d", REQ[i], i), upc, VEC[i][16:8], op_byte, VEC[i][7:0]);
    end
    // r10_: a new byte_in without load or dispatch leaves both outputs alone
    succ_addr = 9'h1FF; {sel_neg, sel_zero, dispatch, alu_neg, alu_zero, byte_load} = 6'b000000;
    byte_in = 8'hEE;
    @(negedge clk);
    check("R10 idle byte_in", upc, 9'h1FF, op_byte, 8'h81);
    // R1 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1 check("R1 async", upc, 9'h000, op_byte, 8'h00);
    @(negedge clk);
    check("R1 held", upc, 9'h000, op_byte, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule